// File: doc/BRIEF.md
# Supply Voltage Monitor Controller

This block is the digital side of a supply supervisor. Analog comparators, which are outside the block, produce one result bit for each of three internal supply thresholds (low, middle, high) and one for an external monitor input compared against the internal reference. A result bit is 1 when the watched voltage is above its threshold and 0 when it is below. Software writes a 4-bit control word that selects a mode and an interrupt mask. It reads back a status word whose bit 0 shows whether the selected voltage is above or below its threshold.

Each comparator bit first passes through a two-flop synchroniser. The chosen mode picks one source, one threshold and one slope direction. When that slope appears on the selected synchronised bit, and the mask allows it, the block emits a one-cycle interrupt request. This request is meant for the highest-priority level of the interrupt controller's pending logic.

A three-state machine controls edge detection. `ST_OFF` covers the disabled mode and the two illegal modes. `ST_ARM` lasts one cycle after the mode changes and loads the edge history without comparing it. `ST_WATCH` compares the history with the live level on every cycle. Transitions:
- Any state moves to `ST_ARM` when a write changes the mode to a legal mode.
- Any state moves to `ST_OFF` when a write changes the mode to mode 111, 101 or 000.
- `ST_ARM` moves to `ST_WATCH` on the next cycle.
- `ST_OFF` and `ST_WATCH` otherwise hold.
- Reset enters `ST_OFF`.

Top module: `vmon_ctrl`

## Requirements
- R1: After reset the control word is 1111b, the status read port returns 0011b and the interrupt request is low.
- R2: Control write bits [3:1] are the mode and bit [0] is the mask. The status read port returns {2'b00, mask, level}.
- R3: In mode 111 (disabled) the level bit reads 1 and no interrupt is raised, whatever the comparator inputs do.
- R4: Modes 101 and 000 are illegal. They behave exactly like mode 111.
- R5: Modes 011, 010 and 001 report the high, middle and low supply comparators on the level bit. Modes 110 and 100 report the external comparator.
- R6: Mode 110 raises the interrupt only on a falling external result.
- R7: Mode 100 raises the interrupt only on a rising external result.
- R8: Modes 011, 010 and 001 raise the interrupt only on a falling result of their own supply comparator. Rising results and the other comparators have no effect.
- R9: When the mask bit is 1, no interrupt is raised. When it is 0, the interrupts of R6 to R8 are enabled.
- R10: The interrupt request is high for exactly one cycle. It is visible after the third rising clock edge that follows the comparator change.
- R11: A write that changes the mode clears the edge history. A level difference between the old and the new source never produces an interrupt.
- R12: The level bit follows a comparator change after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Control write strobe, sampled on the rising edge |
| io_wdata | input | 4 | Control word {mode[2:0], mask} |
| io_rdata | output | 4 | Status word {2'b00, mask, level} |
| cmp_lvl | input | 4 | Comparator results: [0] low, [1] middle, [2] high, [3] external |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
On every cycle, the embedded assertions check these rules:
- A request never follows a cycle in which the mask was set.
- A request never follows a cycle spent in `ST_OFF` or `ST_ARM`.
- Every request follows a cycle in `ST_WATCH`.

Only the bench scenarios can show:
- that the correct source and slope are chosen for each mode code;
- the latency of the level bit and of the request;
- that a mode switch between differing sources stays silent.

The bench sweeps all eight mode codes, both mask values, all four comparators and both slope directions for these checks.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int MODE_W   = 3;
    localparam int CTRL_W   = MODE_W + 1;
    localparam int SRC_LO   = 0;
    localparam int SRC_MID  = 1;
    localparam int SRC_HI   = 2;
    localparam int SRC_EXT  = 3;

    typedef struct packed {
        logic             legal;
        logic [SRC_W-1:0] src;
        logic             on_fall;
    } vmon_sel_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARM,
        ST_WATCH
    } vmon_state_t;

    function automatic vmon_sel_t decode_mode(input logic [MODE_W-1:0] m);
        vmon_sel_t s;
        s = '0;
        unique case (m)
            3'b110:  s = '{legal: 1'b1, src: SRC_W'(SRC_EXT), on_fall: 1'b1};
            3'b100:  s = '{legal: 1'b1, src: SRC_W'(SRC_EXT), on_fall: 1'b0};
            3'b011:  s = '{legal: 1'b1, src: SRC_W'(SRC_HI),  on_fall: 1'b1};
            3'b010:  s = '{legal: 1'b1, src: SRC_W'(SRC_MID), on_fall: 1'b1};
            3'b001:  s = '{legal: 1'b1, src: SRC_W'(SRC_LO),  on_fall: 1'b1};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
    parameter int   WIDTH     = 4,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= {WIDTH{RESET_VAL}};
            end else if (g == 0) begin
                stage_q[g] <= d_in;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/vmon_regs.sv
module vmon_regs
    import vmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              mask_q,
    output logic              mode_chg,
    output logic [MODE_W-1:0] mode_next
);

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= {CTRL_W{1'b1}};
        end else if (wr) begin
            ctrl_q <= wdata;
        end
    end

    assign mode_q    = ctrl_q[CTRL_W-1:1];
    assign mask_q    = ctrl_q[0];
    assign mode_next = wdata[CTRL_W-1:1];
    assign mode_chg  = wr && (wdata[CTRL_W-1:1] != ctrl_q[CTRL_W-1:1]);

endmodule

// File: rtl/vmon_fsm.sv
module vmon_fsm
    import vmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl,
    input  logic [MODE_W-1:0]  mode_q,
    input  logic               mask_q,
    input  logic               mode_chg,
    input  logic [MODE_W-1:0]  mode_next,
    output logic               irq,
    output logic               status
);

    vmon_state_t state_q, state_d;
    vmon_sel_t   cur_sel, nxt_sel;
    logic        sel_lvl, hist_q, edge_hit, irq_q;

    assign cur_sel  = decode_mode(mode_q);
    assign nxt_sel  = decode_mode(mode_next);
    assign sel_lvl  = lvl[cur_sel.src];
    assign status   = cur_sel.legal ? sel_lvl : 1'b1;
    assign edge_hit = cur_sel.on_fall ? (hist_q & ~sel_lvl) : (~hist_q & sel_lvl);

    always_comb begin
        state_d = state_q;
        if (mode_chg) begin
            state_d = nxt_sel.legal ? ST_ARM : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_ARM:   state_d = ST_WATCH;
                ST_WATCH: state_d = ST_WATCH;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    hist_q <= 1'b1;
                    irq_q  <= 1'b0;
                end
                ST_ARM: begin
                    hist_q <= sel_lvl;
                    irq_q  <= 1'b0;
                end
                ST_WATCH: begin
                    hist_q <= sel_lvl;
                    irq_q  <= edge_hit && !mask_q;
                end
                default: begin
                    hist_q <= 1'b1;
                    irq_q  <= 1'b0;
                end
            endcase
        end
    end

    assign irq = irq_q;

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(!mask_q));

    // R3 and R4: the disabled and illegal modes stay silent
    assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !irq_q);

    assert_arm_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> !irq_q);

    assert_irq_from_watch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(state_q == ST_WATCH));

endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
    import vmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic [CTRL_W-1:0]  io_wdata,
    output logic [CTRL_W-1:0]  io_rdata,
    input  logic [NUM_SRC-1:0] cmp_lvl,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] lvl_sync;
    logic [MODE_W-1:0]  mode_q, mode_next;
    logic               mask_q, mode_chg, status;

    vmon_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cmp_lvl),
        .d_out (lvl_sync)
    );

    vmon_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (io_wr),
        .wdata     (io_wdata),
        .mode_q    (mode_q),
        .mask_q    (mask_q),
        .mode_chg  (mode_chg),
        .mode_next (mode_next)
    );

    vmon_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl_sync),
        .mode_q    (mode_q),
        .mask_q    (mask_q),
        .mode_chg  (mode_chg),
        .mode_next (mode_next),
        .irq       (irq_req),
        .status    (status)
    );

    assign io_rdata = {{(CTRL_W-2){1'b0}}, mask_q, status};

endmodule

// File: tb/vmon_ctrl_tb.sv
`timescale 1ns/1ps
module vmon_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [3:0] io_wdata = 4'h0;
    logic [3:0] io_rdata;
    logic [3:0] cmp_lvl = 4'hF;
    logic       irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vmon_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cmp_lvl(cmp_lvl), .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        io_wr = 1'b1; io_wdata = v;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0;
    endtask

    function automatic logic exp_level(input logic [2:0] m, input logic [3:0] p);
        case (m)
            3'b110, 3'b100: return p[3];
            3'b011:         return p[2];
            3'b010:         return p[1];
            3'b001:         return p[0];
            default:        return 1'b1;
        endcase
    endfunction

    function automatic logic exp_fire(input logic [2:0] m, input int idx, input logic rising);
        case (m)
            3'b110:  return idx == 3 && !rising;
            3'b100:  return idx == 3 && rising;
            3'b011:  return idx == 2 && !rising;
            3'b010:  return idx == 1 && !rising;
            3'b001:  return idx == 0 && !rising;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [4:0] seen;
        logic [4:0] want;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", io_rdata, 4'b0011);
        check("R1 reset irq", irq_req, 0);

        wr_ctrl(4'b1110);
        check("R2 mask readback", io_rdata, 4'b0001);

        // R3 R4 R5: level bit for every mode and input pattern
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 16; p++) begin
                wr_ctrl({m[2:0], 1'b1});
                cmp_lvl = p[3:0];
                wait_cyc(3);
                check(m == 7 ? "R3 level" : (m == 5 || m == 0) ? "R4 level" : "R5 level",
                      io_rdata, {2'b00, 1'b1, exp_level(m[2:0], p[3:0])});
            end
        end

        // R6 R7 R8 R9 R10: interrupt sweep
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 2; k++) begin
                for (int i = 0; i < 4; i++) begin
                    for (int r = 0; r < 2; r++) begin
                        cmp_lvl = (r == 1) ? 4'h0 : 4'hF;
                        wait_cyc(4);
                        wr_ctrl({m[2:0], k[0]});
                        wait_cyc(4);
                        cmp_lvl[i] = (r == 1);
                        seen = '0;
                        for (int c = 0; c < 5; c++) begin
                            @(posedge clk); @(negedge clk);
                            seen[c] = irq_req;
                        end
                        want = (exp_fire(m[2:0], i, r[0]) && k == 0) ? 5'b00100 : 5'b00000;
                        check(k == 1 ? "R9 masked irq" : (m == 6) ? "R6 irq" :
                              (m == 4) ? "R7 irq" : "R8 R10 irq", seen, want);
                    end
                end
            end
        end

        // R12: level latency
        wr_ctrl(4'b0101);
        cmp_lvl = 4'hF;
        wait_cyc(4);
        cmp_lvl[1] = 1'b0;
        wait_cyc(1);
        check("R12 level after one edge", io_rdata[0], 1);
        wait_cyc(1);
        check("R12 level after two edges", io_rdata[0], 0);

        // R11: mode switch between differing sources is silent
        cmp_lvl = 4'b0100;
        wr_ctrl(4'b0110);
        wait_cyc(4);
        wr_ctrl(4'b0010);
        seen = '0;
        for (int c = 0; c < 5; c++) begin
            @(posedge clk); @(negedge clk);
            seen[c] = irq_req;
        end
        check("R11 silent mode switch", seen, 0);
        cmp_lvl[0] = 1'b1;
        wait_cyc(4);
        cmp_lvl[0] = 1'b0;
        wait_cyc(3);
        check("R11 watch resumes", irq_req, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule